// File: doc/BRIEF.md
# Call and Interrupt Stack Engine

This block moves program-counter frames and single data bytes between a processor core and a byte-wide stack kept in the register file. The core sends one request: push a data byte, pop a data byte, save a call frame, restore a call frame, save an interrupt frame or restore an interrupt frame. The engine then sends one byte per cycle through a simple register-file port. The port has a write strobe, a read strobe, an 8-bit address and combinational read data. The engine updates its own 8-bit stack pointer as each byte goes.

A call frame is two bytes: the program counter high part and then the low part. The low byte therefore ends up on top of the stack. An interrupt frame adds the flags byte after the two PC bytes, so the flags sit on top. The restore operations read the bytes back in the reverse order. They return the 12-bit program counter, the flags byte or the popped data byte on holding outputs. While a frame is in flight the engine shows busy. It pulses done for one cycle when the frame is finished. Software sets the stack pointer through a load port, normally to C0H, so that the first byte lands at BFH.

Top module: `stk_frame_engine`

## Requirements
- R1: When busy is low, a request with req_valid high and req_op in 0..5 (0 push byte, 1 pop byte, 2 call save, 3 call restore, 4 interrupt save, 5 interrupt restore) is accepted, and busy is high in the next cycle. Op codes 6 and 7, and any request made while busy is high, are ignored.
- R2: Each pushed byte is written with rf_we at address SP-1 (mod 256), one byte per cycle, and SP takes that address in the next cycle.
- R3: Each popped byte is read with rf_re at address SP, and SP becomes SP+1 (mod 256) in the next cycle.
- R4: A call save writes the PC high byte first, {4'b0, pc[11:8]}, and then pc[7:0]. The low byte therefore sits at the lower address.
- R5: An interrupt save writes the PC high byte, then the PC low byte, then the flags byte, so the flags end at the lowest address.
- R6: A call restore reads the low byte and then the high byte, and sets pc_out to {high[3:0], low}. The upper four bits of the high byte are ignored.
- R7: An interrupt restore reads flags, then the PC low byte, then the PC high byte. It updates flags_out and pc_out.
- R8: busy stays high for exactly the frame length in cycles (1, 2 or 3). done is a one-cycle pulse in the cycle after the last byte, with busy low. A new request may be accepted in that cycle.
- R9: The stack pointer wraps: a push at SP=00H writes address FFH, and a pop at SP=FFH leaves SP at 00H.
- R10: wrap_warn is high exactly in push byte cycles whose write address is C0H or above. This includes the wrap from 00H to FFH.
- R11: After reset SP is C0H, busy and done are low, and pc_out, flags_out and pop_data are zero. sp_wr_en loads sp_wr_val only in a cycle where busy is low and no request is accepted. Otherwise the load is ignored.
- R12: A pop byte request returns the byte read on pop_data. The value holds until the next pop byte request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R1) |
| req_data | input | 8 | Byte for a push request |
| req_pc | input | 12 | Program counter to save |
| req_flags | input | 8 | Flags byte to save on interrupt entry |
| sp_wr_en | input | 1 | Stack pointer load strobe |
| sp_wr_val | input | 8 | Stack pointer load value |
| rf_we | output | 1 | Register-file write strobe |
| rf_re | output | 1 | Register-file read strobe |
| rf_addr | output | 8 | Register-file byte address |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data, valid in the same cycle as rf_re |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 8 | Current stack pointer |
| wrap_warn | output | 1 | Push outside the normal stack range |
| pc_out | output | 12 | Restored program counter |
| flags_out | output | 8 | Restored flags |
| pop_data | output | 8 | Last popped data byte |

## Verification
Save and restore are paired with each other and also run against memory that the bench has filled beforehand. The paired runs show that frame order and pointer direction agree with each other. The pre-filled runs show that the order is also absolute: a call restore returns a PC whose high nibble comes only from the lower four bits of the stored byte. Runs at stack pointer 01H, FFH and C1H separate correct 8-bit wraparound and warning decode from sign or range mistakes. Requests and pointer loads sent while busy, illegal op codes, and a pointer load in the same cycle as an accepted request test the acceptance rules. Back-to-back requests issued in the done cycle and a random mix of operations stress the sequencing between frames.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_PUSH    = 3'd0,
        OP_POP     = 3'd1,
        OP_CALL    = 3'd2,
        OP_RET     = 3'd3,
        OP_IENTER  = 3'd4,
        OP_IRETURN = 3'd5
    } stk_op_e;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_PCLO  = 2'd1,
        SEL_PCHI  = 2'd2,
        SEL_FLAGS = 2'd3
    } byte_sel_e;

    localparam int unsigned IDX_W = 2;

    function automatic logic op_known(logic [2:0] op);
        return op <= 3'd5;
    endfunction

    function automatic logic op_pushes(stk_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_IENTER);
    endfunction

    // index of the final byte of a frame
    function automatic logic [IDX_W-1:0] op_last(stk_op_e op);
        case (op)
            OP_CALL, OP_RET:        return 2'd1;
            OP_IENTER, OP_IRETURN:  return 2'd2;
            default:                return 2'd0;
        endcase
    endfunction

    // which byte of the frame moves at position idx
    function automatic byte_sel_e op_byte(stk_op_e op, logic [IDX_W-1:0] idx);
        byte_sel_e s;
        s = SEL_DATA;
        case (op)
            OP_CALL:    s = (idx == 2'd0) ? SEL_PCHI : SEL_PCLO;
            OP_RET:     s = (idx == 2'd0) ? SEL_PCLO : SEL_PCHI;
            OP_IENTER:  s = (idx == 2'd0) ? SEL_PCHI :
                            (idx == 2'd1) ? SEL_PCLO : SEL_FLAGS;
            OP_IRETURN: s = (idx == 2'd0) ? SEL_FLAGS :
                            (idx == 2'd1) ? SEL_PCLO : SEL_PCHI;
            default:    s = SEL_DATA;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_op,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       push_en,
    output logic       pop_en,
    output byte_sel_e  sel
);

    typedef struct packed {
        logic             run;
        stk_op_e          op;
        logic [IDX_W-1:0] idx;
        logic             done;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = !s_q.run && req_valid && op_known(req_op);
        if (s_q.run) begin
            if (s_q.idx == op_last(s_q.op)) begin
                s_d.run  = 1'b0;
                s_d.idx  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end else if (accept) begin
            s_d.run = 1'b1;
            s_d.op  = stk_op_e'(req_op);
            s_d.idx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{run: 1'b0, op: OP_PUSH, idx: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.run;
    assign done    = s_q.done;
    assign push_en = s_q.run && op_pushes(s_q.op);
    assign pop_en  = s_q.run && !op_pushes(s_q.op);
    assign sel     = op_byte(s_q.op, s_q.idx);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && (req_op <= 3'd5)) |=> busy);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_on_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int unsigned         SP_W        = 8,
    parameter logic [SP_W-1:0]     SP_RESET    = 8'hC0,
    parameter logic [SP_W-1:0]     STACK_LIMIT = 8'hC0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [SP_W-1:0] ld_val,
    input  logic            dec,
    input  logic            inc,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] push_addr,
    output logic            warn
);

    typedef struct packed {
        logic [SP_W-1:0] sp;
    } ptr_t;

    ptr_t p_q, p_d;

    always_comb begin
        p_d       = p_q;
        push_addr = p_q.sp - 1'b1;
        if (dec) begin
            p_d.sp = push_addr;
        end else if (inc) begin
            p_d.sp = p_q.sp + 1'b1;
        end else if (ld_en) begin
            p_d.sp = ld_val;
        end
        warn = dec && ((p_q.sp == '0) || (push_addr >= STACK_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.sp <= SP_RESET;
        end else begin
            p_q <= p_d;
        end
    end

    assign sp = p_q.sp;

    p_single_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && inc));

endmodule

// File: rtl/stk_result.sv
module stk_result
    import stk_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [DW-1:0]   req_data,
    input  logic [PC_W-1:0] req_pc,
    input  logic [DW-1:0]   req_flags,
    input  logic            pop_en,
    input  byte_sel_e       sel,
    input  logic [DW-1:0]   rdata,
    output logic [DW-1:0]   wdata,
    output logic [PC_W-1:0] pc_out,
    output logic [DW-1:0]   flags_out,
    output logic [DW-1:0]   pop_data
);

    localparam int unsigned PCH_W = PC_W - DW;

    typedef struct packed {
        logic [DW-1:0]   opnd_data;
        logic [PC_W-1:0] opnd_pc;
        logic [DW-1:0]   opnd_flags;
        logic [DW-1:0]   res_data;
        logic [PC_W-1:0] res_pc;
        logic [DW-1:0]   res_flags;
    } hold_t;

    hold_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        if (accept) begin
            h_d.opnd_data  = req_data;
            h_d.opnd_pc    = req_pc;
            h_d.opnd_flags = req_flags;
        end
        if (pop_en) begin
            case (sel)
                SEL_DATA:  h_d.res_data           = rdata;
                SEL_PCLO:  h_d.res_pc[DW-1:0]     = rdata;
                SEL_PCHI:  h_d.res_pc[PC_W-1:DW]  = rdata[PCH_W-1:0];
                default:   h_d.res_flags          = rdata;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_DATA:  wdata = h_q.opnd_data;
            SEL_PCLO:  wdata = h_q.opnd_pc[DW-1:0];
            SEL_PCHI:  wdata = DW'(h_q.opnd_pc >> DW);
            default:   wdata = h_q.opnd_flags;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign pc_out    = h_q.res_pc;
    assign flags_out = h_q.res_flags;
    assign pop_data  = h_q.res_data;

endmodule

// File: rtl/stk_frame_engine.sv
module stk_frame_engine
    import stk_pkg::*;
#(
    parameter int unsigned     DW          = 8,
    parameter int unsigned     PC_W        = 12,
    parameter int unsigned     SP_W        = 8,
    parameter logic [SP_W-1:0] SP_RESET    = 8'hC0,
    parameter logic [SP_W-1:0] STACK_LIMIT = 8'hC0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [DW-1:0]   req_data,
    input  logic [PC_W-1:0] req_pc,
    input  logic [DW-1:0]   req_flags,
    input  logic            sp_wr_en,
    input  logic [SP_W-1:0] sp_wr_val,
    output logic            rf_we,
    output logic            rf_re,
    output logic [SP_W-1:0] rf_addr,
    output logic [DW-1:0]   rf_wdata,
    input  logic [DW-1:0]   rf_rdata,
    output logic            busy,
    output logic            done,
    output logic [SP_W-1:0] sp_out,
    output logic            wrap_warn,
    output logic [PC_W-1:0] pc_out,
    output logic [DW-1:0]   flags_out,
    output logic [DW-1:0]   pop_data
);

    logic            accept;
    logic            push_en;
    logic            pop_en;
    byte_sel_e       sel;
    logic [SP_W-1:0] push_addr;
    logic            ld_ok;

    stk_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .push_en   (push_en),
        .pop_en    (pop_en),
        .sel       (sel)
    );

    assign ld_ok = sp_wr_en && !busy && !accept;

    stk_ptr #(
        .SP_W        (SP_W),
        .SP_RESET    (SP_RESET),
        .STACK_LIMIT (STACK_LIMIT)
    ) i_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_ok),
        .ld_val    (sp_wr_val),
        .dec       (push_en),
        .inc       (pop_en),
        .sp        (sp_out),
        .push_addr (push_addr),
        .warn      (wrap_warn)
    );

    stk_result #(
        .DW   (DW),
        .PC_W (PC_W)
    ) i_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_data  (req_data),
        .req_pc    (req_pc),
        .req_flags (req_flags),
        .pop_en    (pop_en),
        .sel       (sel),
        .rdata     (rf_rdata),
        .wdata     (rf_wdata),
        .pc_out    (pc_out),
        .flags_out (flags_out),
        .pop_data  (pop_data)
    );

    assign rf_we   = push_en;
    assign rf_re   = pop_en;
    assign rf_addr = push_en ? push_addr : sp_out;

    p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> (sp_out == $past(rf_addr)));

    p_pop_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |=> (sp_out == SP_W'($past(rf_addr) + 1'b1)));

    p_sp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rf_we && !rf_re && !sp_wr_en) |=> $stable(sp_out));

    p_warn_push_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_warn |-> rf_we);

    p_port_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && rf_re));

endmodule

// File: tb/test_stk_frame_engine.sv
module test_stk_frame_engine;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, req_valid, sp_wr_en;
    logic [2:0]  req_op;
    logic [7:0]  req_data, req_flags, sp_wr_val;
    logic [11:0] req_pc;
    logic        rf_we, rf_re, busy, done, wrap_warn;
    logic [7:0]  rf_addr, rf_wdata, rf_rdata, sp_out, flags_out, pop_data;
    logic [11:0] pc_out;

    logic [7:0]  rf_mem  [256];
    logic [7:0]  ref_mem [256];

    assign rf_rdata = rf_mem[rf_addr];
    always @(posedge clk) if (rf_we) rf_mem[rf_addr] <= rf_wdata;

    stk_frame_engine i_stk_frame_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .req_pc(req_pc), .req_flags(req_flags),
        .sp_wr_en(sp_wr_en), .sp_wr_val(sp_wr_val),
        .rf_we(rf_we), .rf_re(rf_re), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata), .busy(busy), .done(done), .sp_out(sp_out),
        .wrap_warn(wrap_warn), .pc_out(pc_out), .flags_out(flags_out),
        .pop_data(pop_data)
    );

    // behavioural reference: a queue of byte moves per frame
    int  m_sp, m_pc, m_flags, m_data, m_op, m_tmp;
    bit  m_done;
    bit  q_wr[$];
    int  q_val[$];
    int  n_cmp = 0, n_bad = 0, cycles = 0;
    bit  checking = 1'b0;

    function automatic void plan(bit w, int v);
        q_wr.push_back(w);
        q_val.push_back(v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sp = 'hC0; m_done = 0; m_pc = 0; m_flags = 0; m_data = 0; m_op = 0;
            q_wr.delete(); q_val.delete();
        end else begin
            m_done = 0;
            if (q_wr.size() > 0) begin
                if (q_wr[0]) begin
                    m_sp = (m_sp + 255) % 256;
                    ref_mem[m_sp] = 8'(q_val[0]);
                end else begin
                    m_tmp = int'(ref_mem[m_sp]);
                    case (q_val[0])
                        0: m_data  = m_tmp;
                        1: m_pc    = (m_pc & 'hF00) | m_tmp;
                        2: m_pc    = (m_pc & 'hFF) | ((m_tmp & 15) << 8);
                        default: m_flags = m_tmp;
                    endcase
                    m_sp = (m_sp + 1) % 256;
                end
                void'(q_wr.pop_front());
                void'(q_val.pop_front());
                if (q_wr.size() == 0) m_done = 1;
            end else if (req_valid && req_op <= 3'd5) begin
                m_op = int'(req_op);
                case (req_op)
                    3'd0: plan(1, int'(req_data));
                    3'd1: plan(0, 0);
                    3'd2: begin plan(1, int'(req_pc) >> 8); plan(1, int'(req_pc) & 255); end
                    3'd3: begin plan(0, 1); plan(0, 2); end
                    3'd4: begin plan(1, int'(req_pc) >> 8); plan(1, int'(req_pc) & 255);
                                plan(1, int'(req_flags)); end
                    default: begin plan(0, 3); plan(0, 1); plan(0, 2); end
                endcase
            end else if (sp_wr_en) begin
                m_sp = int'(sp_wr_val);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            automatic bit ew = (q_wr.size() > 0) && q_wr[0];
            automatic bit er = (q_wr.size() > 0) && !q_wr[0];
            automatic int pa = (m_sp + 255) % 256;
            chk("R1 busy", 32'(busy), 32'(q_wr.size() > 0));
            chk("R8 done", 32'(done), 32'(m_done));
            chk("R2 write strobe", 32'(rf_we), 32'(ew));
            chk("R3 read strobe", 32'(rf_re), 32'(er));
            if (ew) begin
                chk("R2 write address", 32'(rf_addr), 32'(pa));
                chk(m_op == 4 ? "R5 frame byte" : (m_op == 2 ? "R4 frame byte" : "R2 pushed byte"),
                    32'(rf_wdata), 32'(q_val[0]));
                chk("R10 wrap warn", 32'(wrap_warn), 32'(pa >= 'hC0));
            end else begin
                chk("R10 wrap warn idle", 32'(wrap_warn), 32'(0));
            end
            if (er) chk("R3 read address", 32'(rf_addr), 32'(m_sp));
            chk("R9 stack pointer", 32'(sp_out), 32'(m_sp));
            chk(m_op == 5 ? "R7 pc" : "R6 pc", 32'(pc_out), 32'(m_pc));
            chk("R7 flags", 32'(flags_out), 32'(m_flags));
            chk("R12 pop data", 32'(pop_data), 32'(m_data));
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_bad++;
            $display("FAIL R8 watchdog: actual=hang expected=done");
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic req(int op, int d, int pc, int fl, bit noise);
        req_valid = 1; req_op = 3'(op); req_data = 8'(d); req_pc = 12'(pc); req_flags = 8'(fl);
        tick();
        req_valid = 0;
        if (noise) begin
            req_valid = 1; req_op = 3'd0; req_data = 8'hEE;
            sp_wr_en = 1; sp_wr_val = 8'h10;
            tick();
            req_valid = 0; sp_wr_en = 0;
        end
        while (done !== 1'b1) tick();
    endtask

    task automatic load_sp(int v);
        sp_wr_en = 1; sp_wr_val = 8'(v);
        tick();
        sp_wr_en = 0;
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_op = 0; req_data = 0; req_pc = 0;
        req_flags = 0; sp_wr_en = 0; sp_wr_val = 0;
        for (int i = 0; i < 256; i++) begin
            rf_mem[i]  = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        #1 rst_n = 1; checking = 1;
        tick();
        // R11 reset state
        chk("R11 reset sp", 32'(sp_out), 32'hC0);
        chk("R11 reset busy", 32'(busy), 32'(0));
        chk("R11 reset pc", 32'(pc_out), 32'(0));

        // R12 push then pop
        req(0, 'hA5, 0, 0, 0);
        req(1, 0, 0, 0, 0);
        chk("R12 popped value", 32'(pop_data), 32'hA5);
        // R4 / R6 call then return
        req(2, 0, 'h3A7, 0, 0);
        req(3, 0, 0, 0, 0);
        chk("R6 restored pc", 32'(pc_out), 32'h3A7);
        // R6 upper nibble ignored: high byte F5, low byte 21
        req(0, 'hF5, 0, 0, 0);
        req(0, 'h21, 0, 0, 0);
        req(3, 0, 0, 0, 0);
        chk("R6 nibble ignored", 32'(pc_out), 32'h521);
        // R5 / R7 interrupt save then restore
        req(4, 0, 'hABC, 'h5A, 0);
        req(7'd5, 0, 0, 0, 0);
        chk("R7 restored flags", 32'(flags_out), 32'h5A);
        chk("R7 restored pc", 32'(pc_out), 32'hABC);
        // R1 requests and loads while busy are ignored
        req(2, 0, 'h123, 0, 1);
        chk("R11 load ignored while busy", 32'(sp_out), 32'hBE);
        req(3, 0, 0, 0, 0);
        // R1 undefined op codes ignored
        req_valid = 1; req_op = 3'd6; tick();
        req_op = 3'd7; tick();
        req_valid = 0; tick();
        chk("R1 illegal op ignored", 32'(busy), 32'(0));
        // R11 load in the same cycle as an accepted request is ignored
        sp_wr_en = 1; sp_wr_val = 8'h55;
        req(0, 'h77, 0, 0, 0);
        sp_wr_en = 0;
        chk("R11 load ignored on accept", 32'(sp_out), 32'hBF);
        req(1, 0, 0, 0, 0);
        // R9 / R10 wrap through 00H
        load_sp('h01);
        req(2, 0, 'h9CD, 0, 0);
        chk("R9 wrapped sp", 32'(sp_out), 32'hFF);
        req(3, 0, 0, 0, 0);
        chk("R9 wrapped back", 32'(sp_out), 32'h01);
        chk("R6 pc across wrap", 32'(pc_out), 32'h9CD);
        // R10 limit edge
        load_sp('hC1);
        req(0, 'h3C, 0, 0, 0);
        load_sp('hC0);
        req(4, 0, 'h7E1, 'hC3, 0);
        req(5, 0, 0, 0, 0);
        // R8 back-to-back requests issued in the done cycle, random mix
        for (int k = 0; k < 80; k++) begin
            if (k % 8 == 0) load_sp('hC0);
            req($urandom_range(0, 5), $urandom_range(0, 255),
                $urandom_range(0, 4095), $urandom_range(0, 255), (k % 5) == 0);
        end
        repeat (3) tick();
        summary();
        $finish;
    end

endmodule